// File: doc/BRIEF.md
# Multiprocessor Semaphore Gate Array

This block keeps an array of semaphore gates that several processors share over one simple register bus. Every bus write carries an address, a 16-bit data word and the ID of the master that issues it. Reads are combinational from the address. A gate holds an owner tag, which is the owner's master ID plus one. A value of zero means the gate is free. A processor claims a gate by writing its own tag there, then reads the gate back: the claim was won only if the value read equals the tag it wrote.

A processor whose claim fails gets a notification flag for that gate. Its interrupt line rises once a flagged gate becomes free. Two keyed registers let software recover shared state. Each takes two writes in a row from the same master, with a fixed key byte in each write. One register frees gates and the other clears notification flags. Either can act on a single gate or on every gate, and each shows an armed state while a sequence is half done.

Address map: gate n sits at address n, for n below the gate count. The gate reset register is at 0x40 and the notification reset register is at 0x41. A write to either register carries the key in data bits [7:0] and the target gate number in bits [15:8]. Gate reads return the tag in bits [7:0] with the upper byte zero.

Top module: `sema_gates`

## Requirements
- R1: After reset, every gate reads 0, both reset registers read 0x0000, and both interrupt lines are low.
- R2: A write to a free gate whose data byte equals the writer's master ID plus one stores that tag. Any other data byte written to a free gate leaves it at 0.
- R3: A nonzero write to a gate that holds a tag leaves the tag unchanged.
- R4: A zero write to a locked gate frees it only when the writer's master ID plus one equals the stored tag. Otherwise the tag stays.
- R5: Writing key 0xE2 to the gate reset register and then key 0x1D with a target from the same master frees the target gate and no other gate.
- R6: Reading either reset register returns the sequence state in bits [5:4] (00 idle, 01 first key accepted), the starting master ID in bits [3:0], and the target of the last completed sequence in bits [15:8]. In the idle state, a write whose key is not the first key changes nothing.
- R7: A completed sequence whose target is 64 or above acts on every gate. A target from the gate count up to 63 acts on no gate.
- R8: When the first key has been accepted, the next write to that register returns the state to idle. Nothing is reset if that write's key is wrong or it comes from a different master.
- R9: A tag write by master m to a gate that holds a different owner's tag sets m's flag for that gate. Interrupt m is high while any of m's flagged gates is free.
- R10: The notification reset register uses key 0x47 followed by key 0xB8 and follows the same targeting and abort rules. A completed sequence clears the flags of all masters for the targeted gate or gates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_mid | input | MID_W (1) | ID of the issuing master |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| irq | output | NUM_MASTERS (2) | Per-master notification interrupt |

## Verification
The assertions check every cycle that a held tag only stays the same or drops to zero, that a tag is removed only by its owner's zero write or a completed gate reset, that a notification flag rises only after a write by that master to a locked gate, and that an armed key sequence always returns to idle on the next write. The bench scenarios are needed to show the values themselves. These are the tag read back after a won or lost claim, the exact reset register words, the difference between a single-gate target, an all-gates target and an out-of-range target, the abort cases, and the interrupt rising only once a flagged gate becomes free.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 16;
  localparam logic [ADDR_W-1:0] GRST_ADDR = 7'h40;
  localparam logic [ADDR_W-1:0] NRST_ADDR = 7'h41;
  localparam logic [7:0] GATE_KEY_A = 8'hE2;
  localparam logic [7:0] GATE_KEY_B = 8'h1D;
  localparam logic [7:0] NTFY_KEY_A = 8'h47;
  localparam logic [7:0] NTFY_KEY_B = 8'hB8;
  localparam logic [7:0] ALL_CODE   = 8'd64;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'b00,
    KS_ARMED = 2'b01
  } key_state_e;
endpackage

// File: rtl/sema_key_fsm.sv
module sema_key_fsm
  import sema_pkg::*;
#(
  parameter logic [7:0] KEY_A = 8'hE2,
  parameter logic [7:0] KEY_B = 8'h1D,
  parameter int MID_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wdata,
  input  logic [MID_W-1:0] mid,
  output logic             fire,
  output logic [7:0]       tgt,
  output logic [15:0]      rd_word
);
  key_state_e       state_q, state_d;
  logic [MID_W-1:0] mid_q, mid_d;
  logic [7:0]       last_q, last_d;
  logic             reg_en;
  logic [1:0]       st_bits;
  logic [3:0]       mid_ext;

  always_comb begin
    state_d = state_q;
    mid_d   = mid_q;
    last_d  = last_q;
    fire    = 1'b0;
    tgt     = wdata[15:8];
    case (state_q)
      KS_IDLE: begin
        if (wr_en && wdata[7:0] == KEY_A) begin
          state_d = KS_ARMED;
          mid_d   = mid;
        end
      end
      default: begin
        if (wr_en) begin
          state_d = KS_IDLE;
          if (wdata[7:0] == KEY_B && mid == mid_q) begin
            fire   = 1'b1;
            last_d = wdata[15:8];
          end
        end
      end
    endcase
  end

  assign reg_en  = wr_en;
  assign st_bits = state_q;
  assign mid_ext = 4'(mid_q);
  assign rd_word = {last_q, 2'b00, st_bits, mid_ext};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_IDLE;
      mid_q   <= '0;
      last_q  <= '0;
    end else if (reg_en) begin
      state_q <= state_d;
      mid_q   <= mid_d;
      last_q  <= last_d;
    end
  end

  assert_arm_returns_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_ARMED && wr_en) |=> (state_q == KS_IDLE));

  assert_idle_needs_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_IDLE && !(wr_en && wdata[7:0] == KEY_A)) |=> (state_q == KS_IDLE));

  assert_last_only_on_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire) |=> $stable(last_q));
endmodule

// File: rtl/sema_gate_bank.sv
module sema_gate_bank
  import sema_pkg::*;
#(
  parameter int NUM_GATES   = 16,
  parameter int NUM_MASTERS = 2,
  parameter int MID_W       = 1,
  parameter int GIDX_W      = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   gate_we,
  input  logic [GIDX_W-1:0]      gate_idx,
  input  logic [7:0]             tag,
  input  logic [MID_W-1:0]       mid,
  input  logic                   grst_fire,
  input  logic [7:0]             grst_tgt,
  input  logic                   nrst_fire,
  input  logic [7:0]             nrst_tgt,
  output logic [NUM_GATES*8-1:0] gate_flat,
  output logic [NUM_MASTERS-1:0] irq
);
  logic [7:0]           gate_q [NUM_GATES];
  logic [7:0]           gate_d [NUM_GATES];
  logic [NUM_GATES-1:0] gate_en;
  logic [NUM_GATES-1:0] flag_q [NUM_MASTERS];
  logic [NUM_GATES-1:0] flag_d [NUM_MASTERS];
  logic [NUM_MASTERS-1:0] flag_en;
  logic [NUM_GATES-1:0] free_v;
  logic [7:0]           my_tag;

  assign my_tag = 8'(mid) + 8'd1;

  always_comb begin
    for (int g = 0; g < NUM_GATES; g++) begin
      logic hit, rst_hit;
      hit       = gate_we && (gate_idx == GIDX_W'(g));
      rst_hit   = grst_fire && (grst_tgt >= ALL_CODE || grst_tgt == 8'(g));
      gate_d[g] = gate_q[g];
      if (rst_hit) begin
        gate_d[g] = 8'd0;
      end else if (hit) begin
        if (gate_q[g] == 8'd0 && tag == my_tag)
          gate_d[g] = tag;
        else if (gate_q[g] != 8'd0 && tag == 8'd0 && gate_q[g] == my_tag)
          gate_d[g] = 8'd0;
      end
      gate_en[g] = hit || rst_hit;
      free_v[g]  = (gate_q[g] == 8'd0);
      gate_flat[g*8 +: 8] = gate_q[g];
    end
  end

  always_comb begin
    for (int m = 0; m < NUM_MASTERS; m++) begin
      flag_d[m] = flag_q[m];
      for (int g = 0; g < NUM_GATES; g++) begin
        if (nrst_fire && (nrst_tgt >= ALL_CODE || nrst_tgt == 8'(g)))
          flag_d[m][g] = 1'b0;
        else if (gate_we && gate_idx == GIDX_W'(g) && mid == MID_W'(m) &&
                 tag == my_tag && gate_q[g] != 8'd0 && gate_q[g] != my_tag)
          flag_d[m][g] = 1'b1;
      end
      flag_en[m] = gate_we || nrst_fire;
      irq[m]     = |(flag_q[m] & free_v);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_GATES; g++) gate_q[g] <= '0;
    end else begin
      for (int g = 0; g < NUM_GATES; g++)
        if (gate_en[g]) gate_q[g] <= gate_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < NUM_MASTERS; m++) flag_q[m] <= '0;
    end else begin
      for (int m = 0; m < NUM_MASTERS; m++)
        if (flag_en[m]) flag_q[m] <= flag_d[m];
    end
  end

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate_chk
    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_q[g] != 8'd0) |=> (gate_q[g] == $past(gate_q[g]) || gate_q[g] == 8'd0));

    assert_owner_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_q[g] != 8'd0 && !grst_fire &&
       !(gate_we && gate_idx == GIDX_W'(g) && tag == 8'd0 && (8'(mid) + 8'd1) == gate_q[g]))
      |=> (gate_q[g] == $past(gate_q[g])));

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_flag_chk
      assert_notify_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[m][g]) |-> $past(gate_we && gate_idx == GIDX_W'(g) &&
                                      mid == MID_W'(m) && gate_q[g] != 8'd0));
    end
  end
endmodule

// File: rtl/sema_gates.sv
module sema_gates
  import sema_pkg::*;
#(
  parameter int NUM_GATES   = 16,
  parameter int NUM_MASTERS = 2,
  localparam int MID_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  input  logic [MID_W-1:0]       bus_mid,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic [NUM_MASTERS-1:0] irq
);
  localparam int GIDX_W = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1;

  logic [1:0]             rsync_q;
  logic                   rst_n_int;
  logic                   gate_sel, gate_we, grst_we, nrst_we;
  logic [GIDX_W-1:0]      gidx;
  logic                   grst_fire, nrst_fire;
  logic [7:0]             grst_tgt, nrst_tgt;
  logic [15:0]            grst_word, nrst_word;
  logic [NUM_GATES*8-1:0] gate_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_int = rsync_q[1];

  assign gate_sel = (bus_addr < ADDR_W'(NUM_GATES));
  assign gidx     = bus_addr[GIDX_W-1:0];
  assign gate_we  = bus_we && gate_sel;
  assign grst_we  = bus_we && (bus_addr == GRST_ADDR);
  assign nrst_we  = bus_we && (bus_addr == NRST_ADDR);

  sema_key_fsm #(.KEY_A(GATE_KEY_A), .KEY_B(GATE_KEY_B), .MID_W(MID_W)) u_grst (
    .clk(clk), .rst_n(rst_n_int), .wr_en(grst_we), .wdata(bus_wdata), .mid(bus_mid),
    .fire(grst_fire), .tgt(grst_tgt), .rd_word(grst_word));

  sema_key_fsm #(.KEY_A(NTFY_KEY_A), .KEY_B(NTFY_KEY_B), .MID_W(MID_W)) u_nrst (
    .clk(clk), .rst_n(rst_n_int), .wr_en(nrst_we), .wdata(bus_wdata), .mid(bus_mid),
    .fire(nrst_fire), .tgt(nrst_tgt), .rd_word(nrst_word));

  sema_gate_bank #(
    .NUM_GATES(NUM_GATES), .NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W), .GIDX_W(GIDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n_int), .gate_we(gate_we), .gate_idx(gidx),
    .tag(bus_wdata[7:0]), .mid(bus_mid),
    .grst_fire(grst_fire), .grst_tgt(grst_tgt),
    .nrst_fire(nrst_fire), .nrst_tgt(nrst_tgt),
    .gate_flat(gate_flat), .irq(irq));

  always_comb begin
    bus_rdata = '0;
    if (gate_sel)                    bus_rdata = {8'h00, gate_flat[gidx*8 +: 8]};
    else if (bus_addr == GRST_ADDR)  bus_rdata = grst_word;
    else if (bus_addr == NRST_ADDR)  bus_rdata = nrst_word;
  end

  assert_irq_quiet_in_reset_R1: assert property (@(posedge clk)
    (!rst_n_int) |-> (irq == '0));
endmodule

// File: tb/sim_sema_gates.sv
`timescale 1ns/1ps
module sim_sema_gates;
  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [6:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [0:0]  bus_mid;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;

  int n_cmp;
  int n_bad;
  bit done;

  sema_gates u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_mid(bus_mid), .bus_rdata(bus_rdata), .irq(irq));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d, input logic m);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_mid = m;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic chk_rd(input string req, input logic [6:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    chk_rd("R1 gate0", 7'd0, 16'h0000);
    chk_rd("R1 gate15", 7'd15, 16'h0000);
    chk_rd("R1 greg", 7'h40, 16'h0000);
    chk_rd("R1 nreg", 7'h41, 16'h0000);
    chk("R1 irq", {14'd0, irq}, 16'h0000);
  endtask

  task automatic t_lock();
    wr(7'd3, 16'h0001, 1'b0);
    chk_rd("R2 m0 claims gate3", 7'd3, 16'h0001);
    wr(7'd5, 16'h0001, 1'b1);
    chk_rd("R2 wrong tag ignored", 7'd5, 16'h0000);
  endtask

  task automatic t_contend();
    wr(7'd3, 16'h0002, 1'b1);
    chk_rd("R3 locked gate kept", 7'd3, 16'h0001);
    chk("R9 no irq while held", {14'd0, irq}, 16'h0000);
    wr(7'd3, 16'h0000, 1'b1);
    chk_rd("R4 non-owner release ignored", 7'd3, 16'h0001);
    wr(7'd3, 16'h0000, 1'b0);
    chk_rd("R4 owner release", 7'd3, 16'h0000);
    chk("R9 irq m1 after free", {14'd0, irq}, 16'h0002);
  endtask

  task automatic t_gate_reset();
    wr(7'd7, 16'h0002, 1'b1);
    wr(7'd8, 16'h0001, 1'b0);
    wr(7'h40, 16'h07E2, 1'b0);
    chk_rd("R6 armed word", 7'h40, 16'h0010);
    wr(7'h40, 16'h071D, 1'b0);
    chk_rd("R5 gate7 freed", 7'd7, 16'h0000);
    chk_rd("R5 gate8 kept", 7'd8, 16'h0001);
    chk_rd("R6 idle word", 7'h40, 16'h0700);
  endtask

  task automatic t_abort();
    wr(7'h40, 16'h08E2, 1'b1);
    chk_rd("R6 armed by m1", 7'h40, 16'h0711);
    wr(7'h40, 16'h081D, 1'b0);
    chk_rd("R8 other master aborts", 7'h40, 16'h0701);
    chk_rd("R8 gate8 kept after master abort", 7'd8, 16'h0001);
    wr(7'h40, 16'h08E2, 1'b0);
    chk_rd("R6 armed by m0", 7'h40, 16'h0710);
    wr(7'h40, 16'h0855, 1'b0);
    chk_rd("R8 wrong key aborts", 7'h40, 16'h0700);
    chk_rd("R8 gate8 kept after key abort", 7'd8, 16'h0001);
    wr(7'h40, 16'h081D, 1'b0);
    chk_rd("R6 second key alone ignored", 7'h40, 16'h0700);
    chk_rd("R6 gate8 kept", 7'd8, 16'h0001);
  endtask

  task automatic t_all();
    wr(7'd0, 16'h0002, 1'b1);
    wr(7'd15, 16'h0001, 1'b0);
    wr(7'h40, 16'h20E2, 1'b1);
    wr(7'h40, 16'h201D, 1'b1);
    chk_rd("R7 out-of-range word", 7'h40, 16'h2001);
    chk_rd("R7 out-of-range gate0", 7'd0, 16'h0002);
    chk_rd("R7 out-of-range gate8", 7'd8, 16'h0001);
    wr(7'h40, 16'h40E2, 1'b1);
    wr(7'h40, 16'h401D, 1'b1);
    chk_rd("R7 all word", 7'h40, 16'h4001);
    chk_rd("R7 all gate0", 7'd0, 16'h0000);
    chk_rd("R7 all gate8", 7'd8, 16'h0000);
    chk_rd("R7 all gate15", 7'd15, 16'h0000);
  endtask

  task automatic t_notify();
    chk("R9 flag survives gate reset", {14'd0, irq}, 16'h0002);
    wr(7'h41, 16'h0347, 1'b1);
    wr(7'h41, 16'h03B8, 1'b1);
    chk("R10 single clear", {14'd0, irq}, 16'h0000);
    chk_rd("R10 word", 7'h41, 16'h0301);
    wr(7'd2, 16'h0001, 1'b0);
    wr(7'd2, 16'h0002, 1'b1);
    wr(7'd4, 16'h0002, 1'b1);
    wr(7'd4, 16'h0001, 1'b0);
    chk("R9 held gates no irq", {14'd0, irq}, 16'h0000);
    wr(7'd2, 16'h0000, 1'b0);
    chk("R9 irq m1 only", {14'd0, irq}, 16'h0002);
    wr(7'd4, 16'h0000, 1'b1);
    chk("R9 irq both", {14'd0, irq}, 16'h0003);
    wr(7'h41, 16'h0047, 1'b0);
    wr(7'h41, 16'hFFB8, 1'b1);
    chk("R10 master abort keeps flags", {14'd0, irq}, 16'h0003);
    chk_rd("R10 word after abort", 7'h41, 16'h0300);
    wr(7'h41, 16'h0047, 1'b0);
    wr(7'h41, 16'hFFB8, 1'b0);
    chk("R10 all clear", {14'd0, irq}, 16'h0000);
    chk_rd("R10 all word", 7'h41, 16'hFF00);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 0x0000 expected 0x0001");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; bus_mid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_lock();
    t_contend();
    t_gate_reset();
    t_abort();
    t_all();
    t_notify();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule